// File: doc/BRIEF.md
# Fully Associative Address-Space Translation Buffer

This block holds a small set of page-table entries and answers translation lookups in the same cycle they are asked. Every entry carries a virtual page number tag, an address-space number, a global flag that lets the entry match under any address space, a physical page number and a few attribute bits passed through untouched. A lookup presents a page number and the current address-space number. It returns whether an entry hit, which slot hit, and that slot's contents.

New entries are written through an insert port. They always land at a rotating replacement pointer, which moves forward one slot per insert and wraps after the last slot. Three invalidation commands maintain the contents:
- wipe every entry;
- drop only the entries that are not global;
- drop the entries that a given page number and address-space number would hit.

Permission checks and page-table walks belong to the surrounding logic. The entry count is a parameter; a data-side instance would use 64 slots and an instruction-side one 48.

Top module: `atlb_top`

## Requirements
- R1: A lookup hits on an entry only when the entry is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address-space number equals `lk_asn`.
- R2: When several entries hit, the lowest-numbered slot is reported on `lk_idx` and its fields are returned.
- R3: Lookup is combinational. On a miss, `lk_hit`, `lk_idx`, `lk_global`, `lk_ppn` and `lk_attr` are all zero.
- R4: An accepted insert (`ins_en`=1 while `flush_op`=0) writes the slot at the replacement pointer on the next clock edge. It overwrites whatever was there, marks the slot valid, stores `ins_vpn` as its tag, and advances the pointer by one.
- R5: The replacement pointer wraps from slot ENTRIES-1 to slot 0.
- R6: `flush_op`=1 invalidates every entry and sets the replacement pointer to 0.
- R7: `flush_op`=2 invalidates only the entries whose global flag is clear. Global entries keep hitting, and the replacement pointer is unchanged.
- R8: `flush_op`=3 invalidates every entry that a lookup with `flush_vpn`/`flush_asn` would hit under the R1 rule, including all duplicates. Other entries are untouched.
- R9: When `flush_op` is non-zero in the same cycle as `ins_en`, the flush takes effect and the insert is dropped. No entry is written and the pointer does not advance for it.
- R10: After a synchronous reset (`rst_n`=0 at a clock edge), all entries are invalid and the replacement pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Some entry matched |
| lk_idx | output | IDX_W | Slot of the lowest matching entry |
| lk_global | output | 1 | Global flag of the matching entry |
| lk_ppn | output | PPN_W | Physical page number of the matching entry |
| lk_attr | output | ATTR_W | Attribute bits of the matching entry |
| ins_en | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag for the inserted entry |
| ins_asn | input | ASN_W | Address-space number for the inserted entry |
| ins_global | input | 1 | Global flag for the inserted entry |
| ins_ppn | input | PPN_W | Physical page number for the inserted entry |
| ins_attr | input | ATTR_W | Attribute bits for the inserted entry |
| flush_op | input | 2 | 0 none, 1 all, 2 non-global, 3 single page |
| flush_vpn | input | VPN_W | Page number for a single-page flush |
| flush_asn | input | ASN_W | Address-space number for a single-page flush |

## Verification
The hardest state to reach from the ports is a table holding duplicate tags. One copy is global and one is private to an address space, so a single-page flush has to remove both, and the lowest-slot rule decides which copy a lookup reports. The stimulus inserts the same page number twice, under different address-space settings, at adjacent pointer positions. It then looks the page up from several address spaces before and after the flush. The pointer is not visible at the ports, so its wrap and reset are observed through the slot number that later inserts report on lookup.

// File: rtl/atlb_pkg.sv
// Shared definitions for the address-space translation buffer.
// Assumes: the flush command encoding below is fixed at the block boundary.
package atlb_pkg;
    typedef enum logic [1:0] {
        FL_NONE  = 2'd0,
        FL_ALL   = 2'd1,
        FL_LOCAL = 2'd2,
        FL_PAGE  = 2'd3
    } flush_e;
endpackage

// File: rtl/atlb_match.sv
// Per-slot tag comparator: raises one bit for every slot that a query would hit.
// Assumes: valid, global, tag and address-space vectors are registered state.
module atlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASN_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0]            glob,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
    input  logic [VPN_W-1:0]              q_vpn,
    input  logic [ASN_W-1:0]              q_asn,
    output logic [ENTRIES-1:0]            hits
);
    // one comparator per slot: valid, tag equal, and global or same space
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = valid[g] && (tags[g] == q_vpn) &&
                         (glob[g] || (asns[g] == q_asn));
    end
endmodule

// File: rtl/atlb_prio.sv
// Lowest-index priority encoder over a request vector.
// Assumes: idx is only meaningful when any is set; it is zero otherwise.
module atlb_prio #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    // scan downward so the lowest set bit is the last one assigned
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/atlb_repl_ptr.sv
// Rotating replacement pointer: steps once per accepted insert, wraps at the end.
// Assumes: clr and adv are never both set (flushes suppress inserts upstream).
module atlb_repl_ptr #(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // pointer register: cleared by reset or flush-all, stepped by insert
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ptr <= '0;
        else if (adv)
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1));

    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

    // R6
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ptr == '0);
endmodule

// File: rtl/atlb_store.sv
// Entry storage: per-slot valid, tag, space number, global flag and payload.
// Assumes: ins_go is already qualified (no flush in the same cycle) and
// fmatch is the single-page flush match vector computed from this storage.
module atlb_store
    import atlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASN_W   = 8,
    parameter int PPN_W   = 20,
    parameter int ATTR_W  = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  flush_e                         fop,
    input  logic [ENTRIES-1:0]             fmatch,
    input  logic                           ins_go,
    input  logic [IDX_W-1:0]               ptr,
    input  logic [VPN_W-1:0]               ins_vpn,
    input  logic [ASN_W-1:0]               ins_asn,
    input  logic                           ins_global,
    input  logic [PPN_W-1:0]               ins_ppn,
    input  logic [ATTR_W-1:0]              ins_attr,
    output logic [ENTRIES-1:0]             valid,
    output logic [ENTRIES-1:0]             glob,
    output logic [ENTRIES-1:0][VPN_W-1:0]  tags,
    output logic [ENTRIES-1:0][ASN_W-1:0]  asns,
    output logic [ENTRIES-1:0][PPN_W-1:0]  ppns,
    output logic [ENTRIES-1:0][ATTR_W-1:0] attrs
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic wr_here;
        assign wr_here = ins_go && (ptr == IDX_W'(g));

        // valid bit: flushes take priority over a write to this slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid[g] <= 1'b0;
            else if (fop == FL_ALL)
                valid[g] <= 1'b0;
            else if (fop == FL_LOCAL && !glob[g])
                valid[g] <= 1'b0;
            else if (fop == FL_PAGE && fmatch[g])
                valid[g] <= 1'b0;
            else if (wr_here)
                valid[g] <= 1'b1;
        end

        // entry fields: loaded only by an accepted insert aimed at this slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                glob[g]  <= 1'b0;
                tags[g]  <= '0;
                asns[g]  <= '0;
                ppns[g]  <= '0;
                attrs[g] <= '0;
            end else if (wr_here) begin
                glob[g]  <= ins_global;
                tags[g]  <= ins_vpn;
                asns[g]  <= ins_asn;
                ppns[g]  <= ins_ppn;
                attrs[g] <= ins_attr;
            end
        end
    end

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fop == FL_ALL |=> valid == '0);

    // R7
    flush_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fop == FL_LOCAL |=> (valid & ~glob) == '0);

    // R7
    flush_local_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fop == FL_LOCAL |=> valid == ($past(valid) & $past(glob)));
endmodule

// File: rtl/atlb_top.sv
// Fully associative translation buffer with address-space tagging.
// Lookup is combinational. Insert and flush act at the next clock edge.
// Assumes: at most one flush command per cycle; a flush suppresses a
// same-cycle insert entirely, including the pointer step.
module atlb_top
    import atlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASN_W   = 8,
    parameter int PPN_W   = 20,
    parameter int ATTR_W  = 4,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic              lk_global,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ATTR_W-1:0] ins_attr,
    input  logic [1:0]        flush_op,
    input  logic [VPN_W-1:0]  flush_vpn,
    input  logic [ASN_W-1:0]  flush_asn
);
    flush_e                         fop;
    logic                           ins_go;
    logic [IDX_W-1:0]               ptr;
    logic [ENTRIES-1:0]             valid, glob, lk_hits, fmatch;
    logic [ENTRIES-1:0][VPN_W-1:0]  tags;
    logic [ENTRIES-1:0][ASN_W-1:0]  asns;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppns;
    logic [ENTRIES-1:0][ATTR_W-1:0] attrs;
    logic                           any_hit;
    logic [IDX_W-1:0]               hit_idx;

    // command decode: insert accepted only when no flush is requested
    assign fop    = flush_e'(flush_op);
    assign ins_go = ins_en && (fop == FL_NONE);

    atlb_repl_ptr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .adv(ins_go), .clr(fop == FL_ALL), .ptr(ptr)
    );

    atlb_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W),
        .PPN_W(PPN_W), .ATTR_W(ATTR_W), .IDX_W(IDX_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .fop(fop), .fmatch(fmatch),
        .ins_go(ins_go), .ptr(ptr),
        .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_global(ins_global),
        .ins_ppn(ins_ppn), .ins_attr(ins_attr),
        .valid(valid), .glob(glob), .tags(tags), .asns(asns),
        .ppns(ppns), .attrs(attrs)
    );

    atlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .valid(valid), .glob(glob), .tags(tags), .asns(asns),
        .q_vpn(lk_vpn), .q_asn(lk_asn), .hits(lk_hits)
    );

    atlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .valid(valid), .glob(glob), .tags(tags), .asns(asns),
        .q_vpn(flush_vpn), .q_asn(flush_asn), .hits(fmatch)
    );

    atlb_prio #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_prio (
        .req(lk_hits), .any(any_hit), .idx(hit_idx)
    );

    // result mux: selected slot's fields, all zero on a miss
    always_comb begin
        lk_hit    = any_hit;
        lk_idx    = any_hit ? hit_idx : '0;
        lk_global = any_hit ? glob[hit_idx]  : 1'b0;
        lk_ppn    = any_hit ? ppns[hit_idx]  : '0;
        lk_attr   = any_hit ? attrs[hit_idx] : '0;
    end

    // R2
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_hits[lk_idx] &&
                    ((lk_hits & ((ENTRIES'(1) << lk_idx) - ENTRIES'(1))) == '0)));

    // R3
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_idx == '0 && lk_ppn == '0 && lk_attr == '0 && !lk_global));

    // R8
    flush_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fop == FL_PAGE |=> (valid & $past(fmatch)) == '0);

    // R9
    flush_beats_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && fop != FL_NONE) |=> (ptr == '0 || $stable(ptr)));

    // R7
    local_ptr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fop == FL_LOCAL |=> $stable(ptr));
endmodule

// File: tb/sim_atlb_top.sv
// Directed bench for atlb_top. A reference table kept in the bench is updated
// from the requirements and compared against lookups at the ports.
module sim_atlb_top;
    localparam int N      = 8;
    localparam int VPN_W  = 20;
    localparam int ASN_W  = 8;
    localparam int PPN_W  = 20;
    localparam int ATTR_W = 4;
    localparam int IDX_W  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [ASN_W-1:0]  lk_asn = '0;
    logic              lk_hit, lk_global;
    logic [IDX_W-1:0]  lk_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [ATTR_W-1:0] lk_attr;
    logic              ins_en = 1'b0;
    logic [VPN_W-1:0]  ins_vpn = '0;
    logic [ASN_W-1:0]  ins_asn = '0;
    logic              ins_global = 1'b0;
    logic [PPN_W-1:0]  ins_ppn = '0;
    logic [ATTR_W-1:0] ins_attr = '0;
    logic [1:0]        flush_op = 2'd0;
    logic [VPN_W-1:0]  flush_vpn = '0;
    logic [ASN_W-1:0]  flush_asn = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model
    bit          m_val [N];
    bit          m_glb [N];
    int unsigned m_vpn [N];
    int unsigned m_asn [N];
    int unsigned m_ppn [N];
    int unsigned m_attr[N];
    int          m_ptr;

    always #2 clk = ~clk;

    atlb_top #(.ENTRIES(N), .VPN_W(VPN_W), .ASN_W(ASN_W), .PPN_W(PPN_W),
               .ATTR_W(ATTR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_global(lk_global),
        .lk_ppn(lk_ppn), .lk_attr(lk_attr), .ins_en(ins_en),
        .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_global(ins_global),
        .ins_ppn(ins_ppn), .ins_attr(ins_attr), .flush_op(flush_op),
        .flush_vpn(flush_vpn), .flush_asn(flush_asn)
    );

    function automatic bit m_match(int i, int unsigned v, int unsigned a);
        return m_val[i] && m_vpn[i] == v && (m_glb[i] || m_asn[i] == a);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        m_ptr = 0;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_clear();
    endtask

    // one clock with the given commands; model follows R4, R6-R9
    task automatic step(bit ie, int unsigned v, int unsigned a, bit g,
                        int unsigned p, int unsigned at,
                        int op, int unsigned fv, int unsigned fa);
        bit hitv[N];
        @(negedge clk);
        ins_en = ie; ins_vpn = VPN_W'(v); ins_asn = ASN_W'(a); ins_global = g;
        ins_ppn = PPN_W'(p); ins_attr = ATTR_W'(at);
        flush_op = 2'(op); flush_vpn = VPN_W'(fv); flush_asn = ASN_W'(fa);
        @(negedge clk);
        ins_en = 1'b0; flush_op = 2'd0;
        for (int i = 0; i < N; i++) hitv[i] = m_match(i, fv, fa);
        if (op == 1) m_clear();
        else if (op == 2) begin
            for (int i = 0; i < N; i++) if (!m_glb[i]) m_val[i] = 1'b0;
        end else if (op == 3) begin
            for (int i = 0; i < N; i++) if (hitv[i]) m_val[i] = 1'b0;
        end else if (ie) begin
            m_val[m_ptr] = 1'b1; m_glb[m_ptr] = g; m_vpn[m_ptr] = v;
            m_asn[m_ptr] = a; m_ppn[m_ptr] = p; m_attr[m_ptr] = at;
            m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
        end
    endtask

    task automatic ins(int unsigned v, int unsigned a, bit g, int unsigned p);
        step(1'b1, v, a, g, p, p & 4'hF, 0, 0, 0);
    endtask

    task automatic flush(int op, int unsigned fv, int unsigned fa);
        step(1'b0, 0, 0, 1'b0, 0, 0, op, fv, fa);
    endtask

    // compare a lookup against the model (R1, R2, R3)
    task automatic check_lk(int unsigned v, int unsigned a, string req);
        bit e_hit = 1'b0;
        int e_idx = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_match(i, v, a)) begin e_hit = 1'b1; e_idx = i; end
        lk_vpn = VPN_W'(v); lk_asn = ASN_W'(a);
        #1;
        checks++;
        if (lk_hit !== e_hit ||
            (e_hit && (int'(lk_idx) != e_idx || int'(lk_ppn) != int'(m_ppn[e_idx]) ||
                       int'(lk_attr) != int'(m_attr[e_idx]) || lk_global !== m_glb[e_idx])) ||
            (!e_hit && (lk_idx !== '0 || lk_ppn !== '0 || lk_attr !== '0 || lk_global !== 1'b0))) begin
            errors++;
            $display("FAIL %s vpn=%0h asn=%0h: got hit=%0d idx=%0d ppn=%0h exp hit=%0d idx=%0d ppn=%0h",
                     req, v, a, lk_hit, lk_idx, lk_ppn, e_hit, e_idx,
                     e_hit ? m_ppn[e_idx] : 0);
        end
    endtask

    task automatic t_reset();
        apply_reset();
        check_lk(0, 0, "R10");
        check_lk(20'h12, 3, "R10");
    endtask

    task automatic t_basic();
        ins(20'h100, 1, 1'b0, 20'hA1);
        ins(20'h200, 2, 1'b1, 20'hB2);
        ins(20'h300, 3, 1'b0, 20'hC3);
        check_lk(20'h100, 1, "R1 own space");
        check_lk(20'h100, 2, "R1 other space");
        check_lk(20'h200, 9, "R1 global");
        check_lk(20'h300, 3, "R4 slot2");
        check_lk(20'h301, 3, "R3 tag miss");
    endtask

    task automatic t_dup_and_page();
        ins(20'h400, 5, 1'b1, 20'hD4);
        ins(20'h400, 6, 1'b0, 20'hD5);
        ins(20'h400, 7, 1'b0, 20'hD6);
        check_lk(20'h400, 6, "R2 lowest");
        check_lk(20'h400, 7, "R2 lowest");
        flush(3, 20'h400, 6);
        check_lk(20'h400, 6, "R8 dup gone");
        check_lk(20'h400, 7, "R8 other space kept");
        check_lk(20'h100, 1, "R8 unrelated kept");
    endtask

    task automatic t_wrap();
        for (int k = 0; k < N + 2; k++) ins(20'h800 + k, 4, 1'b0, 20'hE00 + k);
        check_lk(20'h800 + N, 4, "R5 wrapped slot");
        check_lk(20'h800 + N + 1, 4, "R5 wrapped slot");
        check_lk(20'h800, 4, "R4 overwritten");
        check_lk(20'h800 + N - 1, 4, "R4 kept");
    endtask

    task automatic t_local();
        ins(20'h900, 1, 1'b1, 20'hF1);
        ins(20'h901, 1, 1'b0, 20'hF2);
        flush(2, 0, 0);
        check_lk(20'h900, 3, "R7 global kept");
        check_lk(20'h901, 1, "R7 local gone");
        ins(20'h902, 1, 1'b0, 20'hF3);
        check_lk(20'h902, 1, "R7 pointer kept");
    endtask

    task automatic t_all();
        flush(1, 0, 0);
        check_lk(20'h900, 3, "R6 global gone");
        ins(20'hA00, 2, 1'b0, 20'h111);
        check_lk(20'hA00, 2, "R6 pointer zero");
    endtask

    task automatic t_collide();
        step(1'b1, 20'hB00, 2, 1'b0, 20'h222, 2, 2, 0, 0);
        check_lk(20'hB00, 2, "R9 insert dropped");
        ins(20'hB01, 2, 1'b0, 20'h333);
        check_lk(20'hB01, 2, "R9 pointer held");
        step(1'b1, 20'hB02, 2, 1'b1, 20'h444, 1, 1, 0, 0);
        check_lk(20'hB02, 7, "R9 insert dropped");
        ins(20'hB03, 2, 1'b1, 20'h555);
        check_lk(20'hB03, 0, "R9 pointer zero");
    endtask

    initial begin
        m_clear();
        t_reset();
        t_basic();
        t_dup_and_page();
        t_wrap();
        t_local();
        t_all();
        t_collide();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule